// File: doc/BRIEF.md
# Terminal Character Handshake and Interrupt Request Unit

This unit sits between a processor's sequencer and a character terminal. It holds one received character waiting for the program and one transmitted character waiting for the device. Each of these has a one-bit flag, and the flags form a ready/consume handshake. On the input side the device deposits a byte, which raises the receive-full flag. The program takes the byte, which drops the flag. On the output side the program writes a byte, which drops the transmit-ready flag. The device takes the byte, which raises the flag again.

The processor gives it a one-cycle execute strobe for a terminal instruction, together with the six one-hot selector bits of that instruction. The unit returns a load strobe that carries the received byte toward the accumulator's low byte, and a skip request for the program counter.

The unit also keeps the interrupt-enable flip-flop and the pending-request flip-flop. Outside the three fetch slots of the timing counter, the request latches while interrupts are enabled and either flag is raised. Only the sequencer's interrupt-cycle clear strobe removes it, and that strobe also disables interrupts.

Top module: `tio_term_ctrl`

## Requirements
- R1: After reset the receive-full flag is 0, the transmit-ready flag is 1, interrupt enable is 0, the pending request is 0, and both character registers hold 0.
- R2: A device write while receive-full is 0 stores `dev_char` and sets receive-full, both visible one cycle later.
- R3: A device write while receive-full is 1 is ignored: the stored character and the flag do not change.
- R4: Input-character is selected by `io_exec` with `io_sel[5]`. In the same cycle it raises `acc_load` with the stored byte on `rx_char`, and one cycle later receive-full is 0.
- R5: Output-character is selected by `io_exec` with `io_sel[4]`. One cycle later `tx_char` equals the `acc_lo` sampled with the strobe and transmit-ready is 0.
- R6: A device consume while transmit-ready is 0 sets it one cycle later. A consume while it is already 1 is ignored.
- R7: `pc_skip` is raised in the same cycle when `io_sel[3]` (skip on input) is executed with receive-full set, or when `io_sel[2]` (skip on output) is executed with transmit-ready set. It is low otherwise.
- R8: `io_sel[1]` sets interrupt enable and `io_sel[0]` clears it, effective next cycle. If both are given together, the clear wins.
- R9: `irq_clear` clears both the pending request and interrupt enable one cycle later, taking priority over any set.
- R10: When `slot` is 3 or more, interrupt enable is 1, and either flag is 1, the pending request is 1 on the next cycle. Once set, it stays set until `irq_clear`.
- R11: While `slot` is 0, 1 or 2, a pending request that is clear stays clear.
- R12: An input-character that coincides with an accepted device write (receive-full 0) leaves the new character stored and receive-full set. An output-character that coincides with a consume leaves transmit-ready at 0.
- R13: With `io_exec` low, `io_sel` has no effect on any flag, register, `acc_load` or `pc_skip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_exec | input | 1 | Terminal instruction executes this cycle |
| io_sel | input | 6 | One-hot instruction selector: 5 in, 4 out, 3 skip-in, 2 skip-out, 1 int-on, 0 int-off |
| acc_lo | input | 8 | Accumulator low byte |
| slot | input | 4 | Current timing-counter slot |
| irq_clear | input | 1 | Interrupt-cycle final-step strobe |
| dev_wr | input | 1 | Device deposits a character |
| dev_char | input | 8 | Character from the device |
| dev_consume | input | 1 | Device has taken the output character |
| rx_char | output | 8 | Stored received character |
| acc_load | output | 1 | Load `rx_char` into the accumulator low byte |
| tx_char | output | 8 | Stored output character |
| rx_full | output | 1 | Receive-full flag |
| tx_ready | output | 1 | Transmit-ready flag |
| int_en | output | 1 | Interrupt enable |
| irq_pending | output | 1 | Pending interrupt request |
| pc_skip | output | 1 | Request to increment the program counter |

## Verification
`acc_load` and `pc_skip` are combinational. They are due in the same cycle as the execute strobe, so the bench compares them a moment after it drives inputs, which it does on the falling edge. Every flag and character register is due exactly one rising edge after its cause. The bench's reference model steps its state only at that rising edge, and the next comparison, made before the following edge, sees that result. Because every output is compared against the model on every cycle, a change that arrives a cycle early or a cycle late shows as a mismatch.

// File: rtl/tio_pkg.sv
package tio_pkg;
  localparam int SEL_W   = 6;
  localparam int SEL_INP = 5;
  localparam int SEL_OUT = 4;
  localparam int SEL_SKI = 3;
  localparam int SEL_SKO = 2;
  localparam int SEL_ION = 1;
  localparam int SEL_IOF = 0;

  typedef struct packed {
    logic inp;
    logic outp;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
  } io_cmd_t;

  function automatic io_cmd_t decode_io(input logic exec, input logic [SEL_W-1:0] sel);
    io_cmd_t c;
    c.inp  = exec & sel[SEL_INP];
    c.outp = exec & sel[SEL_OUT];
    c.ski  = exec & sel[SEL_SKI];
    c.sko  = exec & sel[SEL_SKO];
    c.ion  = exec & sel[SEL_ION];
    c.iof  = exec & sel[SEL_IOF];
    return c;
  endfunction
endpackage

// File: rtl/tio_rst_sync.sv
module tio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/tio_in_chan.sv
module tio_in_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_wr,
  input  logic [CHAR_W-1:0] dev_char,
  input  logic              cmd_inp,
  output logic [CHAR_W-1:0] data_q,
  output logic              full_q
);
  logic              accept;
  logic              full_d;
  logic              full_en;
  logic [CHAR_W-1:0] data_d;

  always_comb begin
    accept  = dev_wr & ~full_q;
    full_en = accept | cmd_inp;
    full_d  = accept;
    data_d  = dev_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (full_en) full_q <= full_d;
      if (accept)  data_q <= data_d;
    end
  end

  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && !full_q) |=> (full_q && data_q == $past(dev_char)));
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && full_q && !cmd_inp) |=> (full_q && $stable(data_q)));
  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inp && full_q) |=> !full_q);
endmodule

// File: rtl/tio_out_chan.sv
module tio_out_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_outp,
  input  logic [CHAR_W-1:0] acc_lo,
  input  logic              dev_consume,
  output logic [CHAR_W-1:0] data_q,
  output logic              ready_q
);
  logic taken;
  logic ready_en;
  logic ready_d;

  always_comb begin
    taken    = dev_consume & ~ready_q;
    ready_en = cmd_outp | taken;
    ready_d  = ~cmd_outp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      data_q  <= '0;
    end else begin
      if (ready_en) ready_q <= ready_d;
      if (cmd_outp) data_q  <= acc_lo;
    end
  end

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_outp |=> (!ready_q && data_q == $past(acc_lo)));
  a_r6_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_consume && !ready_q && !cmd_outp) |=> ready_q);
endmodule

// File: rtl/tio_irq_ctrl.sv
module tio_irq_ctrl #(
  parameter int SLOT_W      = 4,
  parameter int FETCH_SLOTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ion,
  input  logic              iof,
  input  logic              irq_clear,
  input  logic [SLOT_W-1:0] slot,
  input  logic              fgi,
  input  logic              fgo,
  output logic              ien_q,
  output logic              req_q
);
  localparam logic [SLOT_W-1:0] FETCH_LIM = SLOT_W'(FETCH_SLOTS);

  logic in_fetch;
  logic ien_en;
  logic ien_d;
  logic req_set;
  logic req_en;
  logic req_d;

  always_comb begin
    in_fetch = (slot < FETCH_LIM);
    ien_en   = ion | iof | irq_clear;
    ien_d    = ~(iof | irq_clear);
    req_set  = ~in_fetch & ien_q & (fgi | fgo);
    req_en   = req_set | irq_clear;
    req_d    = ~irq_clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (ien_en) ien_q <= ien_d;
      if (req_en) req_q <= req_d;
    end
  end

  a_r8_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    iof |=> !ien_q);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> (!ien_q && !req_q));
  a_r10_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_clear && slot >= FETCH_LIM && ien_q && (fgi || fgo)) |=> req_q);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !irq_clear) |=> req_q);
  a_r11_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && slot < FETCH_LIM) |=> !req_q);
endmodule

// File: rtl/tio_term_ctrl.sv
module tio_term_ctrl #(
  parameter int CHAR_W      = 8,
  parameter int SLOT_W      = 4,
  parameter int FETCH_SLOTS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       io_exec,
  input  logic [tio_pkg::SEL_W-1:0]  io_sel,
  input  logic [CHAR_W-1:0]          acc_lo,
  input  logic [SLOT_W-1:0]          slot,
  input  logic                       irq_clear,
  input  logic                       dev_wr,
  input  logic [CHAR_W-1:0]          dev_char,
  input  logic                       dev_consume,
  output logic [CHAR_W-1:0]          rx_char,
  output logic                       acc_load,
  output logic [CHAR_W-1:0]          tx_char,
  output logic                       rx_full,
  output logic                       tx_ready,
  output logic                       int_en,
  output logic                       irq_pending,
  output logic                       pc_skip
);
  import tio_pkg::*;

  logic    rst_ns;
  io_cmd_t cmd;

  tio_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  always_comb begin
    cmd      = decode_io(io_exec, io_sel);
    acc_load = cmd.inp;
    pc_skip  = (cmd.ski & rx_full) | (cmd.sko & tx_ready);
  end

  tio_in_chan #(.CHAR_W(CHAR_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_ns),
    .dev_wr   (dev_wr),
    .dev_char (dev_char),
    .cmd_inp  (cmd.inp),
    .data_q   (rx_char),
    .full_q   (rx_full)
  );

  tio_out_chan #(.CHAR_W(CHAR_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_ns),
    .cmd_outp    (cmd.outp),
    .acc_lo      (acc_lo),
    .dev_consume (dev_consume),
    .data_q      (tx_char),
    .ready_q     (tx_ready)
  );

  tio_irq_ctrl #(.SLOT_W(SLOT_W), .FETCH_SLOTS(FETCH_SLOTS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .ion       (cmd.ion),
    .iof       (cmd.iof),
    .irq_clear (irq_clear),
    .slot      (slot),
    .fgi       (rx_full),
    .fgo       (tx_ready),
    .ien_q     (int_en),
    .req_q     (irq_pending)
  );

  a_r7_skip_cause: assert property (@(posedge clk) disable iff (!rst_ns)
    pc_skip |-> (io_exec && ((io_sel[SEL_SKI] && rx_full) || (io_sel[SEL_SKO] && tx_ready))));
  a_r13_idle_no_load: assert property (@(posedge clk) disable iff (!rst_ns)
    !io_exec |-> (!acc_load && !pc_skip));
endmodule

// File: tb/tio_term_ctrl_bench.sv
`timescale 1ns/1ps
module tio_term_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_exec;
  logic [5:0] io_sel;
  logic [7:0] acc_lo;
  logic [3:0] slot;
  logic       irq_clear;
  logic       dev_wr;
  logic [7:0] dev_char;
  logic       dev_consume;
  logic [7:0] rx_char, tx_char;
  logic       acc_load, rx_full, tx_ready, int_en, irq_pending, pc_skip;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bit m_fgi, m_fgo, m_ien, m_r;
  logic [7:0] m_rx, m_tx;

  always #2 clk = ~clk;

  tio_term_ctrl u_tio_term_ctrl (
    .clk(clk), .rst_n(rst_n), .io_exec(io_exec), .io_sel(io_sel), .acc_lo(acc_lo),
    .slot(slot), .irq_clear(irq_clear), .dev_wr(dev_wr), .dev_char(dev_char),
    .dev_consume(dev_consume), .rx_char(rx_char), .acc_load(acc_load), .tx_char(tx_char),
    .rx_full(rx_full), .tx_ready(tx_ready), .int_en(int_en), .irq_pending(irq_pending),
    .pc_skip(pc_skip)
  );

  task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit e_load, e_skip;
    e_load = io_exec && io_sel[5];
    e_skip = io_exec && ((io_sel[3] && m_fgi) || (io_sel[2] && m_fgo));
    cmp("rx_full", {7'd0, rx_full}, {7'd0, m_fgi});
    cmp("tx_ready", {7'd0, tx_ready}, {7'd0, m_fgo});
    cmp("int_en", {7'd0, int_en}, {7'd0, m_ien});
    cmp("irq_pending", {7'd0, irq_pending}, {7'd0, m_r});
    cmp("rx_char", rx_char, m_rx);
    cmp("tx_char", tx_char, m_tx);
    cmp("acc_load", {7'd0, acc_load}, {7'd0, e_load});
    cmp("pc_skip", {7'd0, pc_skip}, {7'd0, e_skip});
  endtask

  task automatic model_step();
    bit inp, outp, ion, iof, nfgi, nfgo, nien, nr;
    inp  = io_exec && io_sel[5];
    outp = io_exec && io_sel[4];
    ion  = io_exec && io_sel[1];
    iof  = io_exec && io_sel[0];
    nfgi = m_fgi; nfgo = m_fgo; nien = m_ien; nr = m_r;
    if (inp) nfgi = 0;
    if (dev_wr && !m_fgi) begin nfgi = 1; m_rx = dev_char; end
    if (dev_consume && !m_fgo) nfgo = 1;
    if (outp) begin nfgo = 0; m_tx = acc_lo; end
    if (ion) nien = 1;
    if (iof || irq_clear) nien = 0;
    if (slot > 2 && m_ien && (m_fgi || m_fgo)) nr = 1;
    if (irq_clear) nr = 0;
    m_fgi = nfgi; m_fgo = nfgo; m_ien = nien; m_r = nr;
  endtask

  task automatic tick();
    #1 check_all();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    io_exec = 0; io_sel = '0; irq_clear = 0; dev_wr = 0; dev_consume = 0;
  endtask

  task automatic instr(input int bitpos, input logic [7:0] acc);
    idle(); io_exec = 1; io_sel = 6'(1 << bitpos); acc_lo = acc; tick(); idle();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); acc_lo = 8'h00; dev_char = 8'h00; slot = 4'd5;
    m_fgi = 0; m_fgo = 1; m_ien = 0; m_r = 0; m_rx = 0; m_tx = 0;
    @(negedge clk);
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    cur_req = "R2";
    dev_wr = 1; dev_char = 8'h41; tick(); idle(); tick();
    cur_req = "R3";
    dev_wr = 1; dev_char = 8'h55; tick(); idle(); tick();
    cur_req = "R7";
    instr(3, 8'h00); tick();
    instr(2, 8'h00); tick();
    cur_req = "R4";
    instr(5, 8'h00); tick();
    cur_req = "R7";
    instr(3, 8'h00); tick();
    cur_req = "R5";
    instr(4, 8'h5A); tick();
    cur_req = "R7";
    instr(2, 8'h00); tick();
    cur_req = "R6";
    dev_consume = 1; tick(); idle(); tick();
    dev_consume = 1; tick(); idle(); tick();
    cur_req = "R13";
    io_exec = 0; io_sel = 6'b111111; acc_lo = 8'hC3; tick(); idle(); tick();
    cur_req = "R11";
    slot = 4'd0; instr(1, 8'h00);
    for (int s = 0; s < 3; s++) begin slot = 4'(s); tick(); end
    cur_req = "R10";
    slot = 4'd3; tick(); slot = 4'd1; tick(); tick();
    cur_req = "R9";
    irq_clear = 1; tick(); idle(); tick();
    cur_req = "R8";
    instr(1, 8'h00); tick();
    idle(); io_exec = 1; io_sel = 6'b000011; tick(); idle(); tick();
    cur_req = "R9";
    instr(1, 8'h00); slot = 4'd4; irq_clear = 1; tick(); idle(); tick(); tick();
    irq_clear = 1; tick(); idle(); slot = 4'd0; tick();
    cur_req = "R12";
    instr(5, 8'h00);
    io_exec = 1; io_sel = 6'b100000; dev_wr = 1; dev_char = 8'h7E; tick(); idle(); tick();
    io_exec = 1; io_sel = 6'b010000; acc_lo = 8'h99; dev_consume = 1; tick(); idle(); tick();
    cur_req = "R6";
    dev_consume = 1; tick(); idle(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule